// File: doc/BRIEF.md
# UART Receive Status and Channel Control

This block is the register face of one UART receive channel. On one side sits a bit-level receiver core, which delivers each finished character with a one-cycle completion strobe and flags for a parity mismatch or a bad stop bit. On the other side sits a simple CPU register bus with a single-cycle write strobe, a read strobe and a combinational read-data path. The block holds the last received character and a buffer-full flag. It keeps three sticky error flags: overrun, parity and framing. It also holds the enable state of the channel, and that state gates the receiver core.

Software reads the character, which frees the buffer. It then reads the status word to find out which error occurred, if any, and writes that same word to a separate clear-trigger register. Each error flag whose bit is 1 in the written word is cleared. The channel is switched on and off only through two trigger registers, one for start and one for stop. A framing error is recovered by a stop followed by a start, after which the receiver waits for the next start bit.

Top module: `uart_rx_ctrl`

## Requirements
- R1: After reset the status word, the data register and the enable-status word all read 0, and `rx_enable` is low.
- R2: A completion strobe while the channel is enabled loads `rx_byte` into the data register (address 0, low bits). In the same cycle it sets the buffer-full flag, which is bit 6 of the status word at address 1.
- R3: A read of address 0 clears the buffer-full flag at the clock edge. If a completion strobe arrives in the same cycle as that read, the read returns the old character, the buffer-full flag stays set with the new character, and no overrun is raised.
- R4: A completion strobe while buffer-full is set, without a data read in the same cycle, sets the overrun flag (status bit 0). The new character replaces the unread one, and buffer-full stays set.
- R5: A completion strobe with `rx_par_err` high sets the parity flag (status bit 1). One with `rx_frm_err` high sets the framing flag (status bit 2). Both flags stay set until they are cleared.
- R6: A write to the clear trigger (address 2) clears each error flag whose bit in the written word (bit 0, 1 or 2) is 1. Flags whose bits are 0 are left alone, and the buffer-full flag is never affected.
- R7: If a clear write and a new error hit the same flag in the same cycle, the flag stays set.
- R8: Writing a word with bit 0 set to address 3 (start) sets the enable state. The same write to address 4 (stop) clears it. A word with bit 0 clear does nothing. The enable state reads at bit 0 of address 5 and drives `rx_enable`.
- R9: While the channel is stopped, completion strobes are ignored: the data register, buffer-full and error flags keep their values.
- R10: The trigger addresses 2, 3 and 4 always read 0. Writes to the data, status and enable-status addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | BUS_W | Write data |
| bus_rd | input | 1 | Read strobe; a read of address 0 frees the buffer |
| bus_rdata | output | BUS_W | Combinational read data for `bus_addr` |
| rx_byte | input | DATA_W | Character from the receiver core |
| rx_done | input | 1 | Character-complete strobe |
| rx_par_err | input | 1 | Parity mismatch, valid with `rx_done` |
| rx_frm_err | input | 1 | Bad stop bit, valid with `rx_done` |
| rx_enable | output | 1 | Enable to the receiver core |

## Verification
Two pairs of functions can land in the same cycle. A CPU data read can meet a character completion, and a clear-trigger write can meet a fresh error on the same flag. The bench drives the completion strobe in the very cycle of the data read, or of the clear write. In the first case it checks that the read returned the old character and that the status word then shows buffer-full without overrun. In the second case it checks that the parity flag survived the clear.

// File: rtl/uart_rxc_pkg.sv
package uart_rxc_pkg;

   // register indices on the CPU bus; the ordering is the address map
   typedef enum int {
      REG_DATA  = 0,
      REG_STAT  = 1,
      REG_CLR   = 2,
      REG_START = 3,
      REG_STOP  = 4,
      REG_ENST  = 5
   } reg_sel_e;

   localparam int N_REGS = 6;

   // status word bit positions; the clear trigger uses the same layout
   localparam int ST_OVR  = 0;
   localparam int ST_PAR  = 1;
   localparam int ST_FRM  = 2;
   localparam int ST_FULL = 6;

   typedef struct packed {
      logic frm;
      logic par;
      logic ovr;
   } err_flags_t;

endpackage

// File: rtl/uart_rxc_regdec.sv
module uart_rxc_regdec
   import uart_rxc_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int BUS_W  = 16,
   parameter int CH_IDX = 0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic              rd,
   output logic [N_REGS-1:0] hit,
   output logic              data_rd,
   output err_flags_t        clr_mask,
   output logic              start_hit,
   output logic              stop_hit
);

   if (ADDR_W < $clog2(N_REGS)) begin : g_chk_addr
      $error("uart_rxc_regdec: ADDR_W too small for register map");
   end
   if (CH_IDX >= BUS_W || ST_FULL >= BUS_W) begin : g_chk_bus
      $error("uart_rxc_regdec: BUS_W too narrow");
   end

   for (genvar i = 0; i < N_REGS; i++) begin : g_hit
      assign hit[i] = (addr == ADDR_W'(i));
   end

   logic clr_wr;

   assign data_rd   = rd & hit[REG_DATA];
   assign clr_wr    = wr & hit[REG_CLR];
   assign start_hit = wr & hit[REG_START] & wdata[CH_IDX];
   assign stop_hit  = wr & hit[REG_STOP]  & wdata[CH_IDX];

   always_comb begin
      clr_mask     = '0;
      clr_mask.ovr = clr_wr & wdata[ST_OVR];
      clr_mask.par = clr_wr & wdata[ST_PAR];
      clr_mask.frm = clr_wr & wdata[ST_FRM];
   end

endmodule

// File: rtl/uart_rxc_flags.sv
module uart_rxc_flags
   import uart_rxc_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_done,
   input  logic              rx_par_err,
   input  logic              rx_frm_err,
   input  logic              data_rd,
   input  err_flags_t        clr_mask,
   output logic [DATA_W-1:0] data_q,
   output logic              full_q,
   output err_flags_t        errs_q
);

   if (DATA_W < 1) begin : g_chk_w
      $error("uart_rxc_flags: DATA_W must be positive");
   end

   logic       done_acc;
   err_flags_t err_new;

   assign done_acc = rx_done & enable;

   always_comb begin
      err_new     = '0;
      err_new.ovr = done_acc & full_q & ~data_rd;
      err_new.par = done_acc & rx_par_err;
      err_new.frm = done_acc & rx_frm_err;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         full_q <= 1'b0;
      end else if (done_acc) begin
         data_q <= rx_byte;
         full_q <= 1'b1;
      end else if (data_rd) begin
         full_q <= 1'b0;
      end
   end

   // new errors take priority over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) errs_q <= '0;
      else        errs_q <= (errs_q & ~clr_mask) | err_new;
   end

   p_full_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_acc |=> full_q);
   p_rd_frees_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !done_acc) |=> !full_q);
   p_no_ovr_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !errs_q.ovr) |=> !errs_q.ovr);
   p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_acc && full_q && !data_rd) |=> (errs_q.ovr && full_q));
   p_par_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (errs_q.par && !clr_mask.par) |=> errs_q.par);
   p_clr_par_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask.par && !(done_acc && rx_par_err)) |=> !errs_q.par);
   p_err_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask.frm && done_acc && rx_frm_err) |=> errs_q.frm);
   p_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !enable && !data_rd) |=> ($stable(data_q) && $stable(full_q)));

endmodule

// File: rtl/uart_rxc_chan.sv
module uart_rxc_chan #(
   parameter bit EN_AT_RESET = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_hit,
   input  logic stop_hit,
   output logic en_q
);

   logic en_rst;

   if (EN_AT_RESET) begin : g_rst_on
      assign en_rst = 1'b1;
   end else begin : g_rst_off
      assign en_rst = 1'b0;
   end

   // stop dominates start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en_q <= en_rst;
      else if (stop_hit)  en_q <= 1'b0;
      else if (start_hit) en_q <= 1'b1;
   end

   p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_hit && !stop_hit) |=> en_q);
   p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_hit |=> !en_q);
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_hit && !stop_hit) |=> $stable(en_q));

endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
   import uart_rxc_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int BUS_W       = 16,
   parameter int DATA_W      = 8,
   parameter int CH_IDX      = 0,
   parameter bit EN_AT_RESET = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [BUS_W-1:0]  bus_wdata,
   input  logic              bus_rd,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_done,
   input  logic              rx_par_err,
   input  logic              rx_frm_err,
   output logic              rx_enable
);

   if (DATA_W > BUS_W) begin : g_chk_data
      $error("uart_rx_ctrl: DATA_W exceeds BUS_W");
   end

   logic [N_REGS-1:0] hit;
   logic              data_rd;
   err_flags_t        clr_mask;
   logic              start_hit;
   logic              stop_hit;
   logic              en_q;
   logic [DATA_W-1:0] data_q;
   logic              full_q;
   err_flags_t        errs_q;

   uart_rxc_regdec #(
      .ADDR_W (ADDR_W),
      .BUS_W  (BUS_W),
      .CH_IDX (CH_IDX)
   ) regdec_i (
      .addr      (bus_addr),
      .wr        (bus_wr),
      .wdata     (bus_wdata),
      .rd        (bus_rd),
      .hit       (hit),
      .data_rd   (data_rd),
      .clr_mask  (clr_mask),
      .start_hit (start_hit),
      .stop_hit  (stop_hit)
   );

   uart_rxc_chan #(
      .EN_AT_RESET (EN_AT_RESET)
   ) chan_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_hit (start_hit),
      .stop_hit  (stop_hit),
      .en_q      (en_q)
   );

   uart_rxc_flags #(
      .DATA_W (DATA_W)
   ) flags_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (en_q),
      .rx_byte    (rx_byte),
      .rx_done    (rx_done),
      .rx_par_err (rx_par_err),
      .rx_frm_err (rx_frm_err),
      .data_rd    (data_rd),
      .clr_mask   (clr_mask),
      .data_q     (data_q),
      .full_q     (full_q),
      .errs_q     (errs_q)
   );

   assign rx_enable = en_q;

   logic [BUS_W-1:0] data_word;

   if (BUS_W > DATA_W) begin : g_pad
      assign data_word = {{(BUS_W-DATA_W){1'b0}}, data_q};
   end else begin : g_nopad
      assign data_word = data_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (hit[REG_DATA]) bus_rdata = data_word;
      if (hit[REG_STAT]) begin
         bus_rdata[ST_OVR]  = errs_q.ovr;
         bus_rdata[ST_PAR]  = errs_q.par;
         bus_rdata[ST_FRM]  = errs_q.frm;
         bus_rdata[ST_FULL] = full_q;
      end
      if (hit[REG_ENST]) bus_rdata[CH_IDX] = en_q;
   end

   p_stopped_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_enable && !(bus_wr && hit[REG_CLR])) |=> $stable(errs_q));

endmodule

// File: tb/uart_rx_ctrl_tb_top.sv
module uart_rx_ctrl_tb_top;

   localparam int AW = 3;
   localparam int BW = 16;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [BW-1:0] bus_wdata = '0;
   logic          bus_rd = 1'b0;
   logic [BW-1:0] bus_rdata;
   logic [DW-1:0] rx_byte = '0;
   logic          rx_done = 1'b0;
   logic          rx_par_err = 1'b0;
   logic          rx_frm_err = 1'b0;
   logic          rx_enable;

   int n_chk  = 0;
   int n_fail = 0;
   bit done_run = 1'b0;

   always #4ns clk = ~clk;   // 125 MHz

   uart_rx_ctrl dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata),
      .bus_rd     (bus_rd),
      .bus_rdata  (bus_rdata),
      .rx_byte    (rx_byte),
      .rx_done    (rx_done),
      .rx_par_err (rx_par_err),
      .rx_frm_err (rx_frm_err),
      .rx_enable  (rx_enable)
   );

   // vector: op[38:37] addr[36:34] data[33:18] par[17] frm[16] exp[15:0]
   localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_F = 2'd2;
   localparam int NV = 32;
   localparam logic [38:0] VEC [NV] = '{
      {OP_R, 3'd5, 16'h0000, 1'b0, 1'b0, 16'h0000},  // R1 enable status
      {OP_R, 3'd1, 16'h0000, 1'b0, 1'b0, 16'h0000},  // R1 status
      {OP_F, 3'd0, 16'h005A, 1'b0, 1'b0, 16'h0000},  // R9 frame while stopped
      {OP_R, 3'd1, 16'h0000, 1'b0, 1'b0, 16'h0000},  // R9
      {OP_R, 3'd0, 16'h0000, 1'b0, 1'b0, 16'h0000},  // R9 data untouched
      {OP_W, 3'd3, 16'h0000, 1'b0, 1'b0, 16'h0000},  // R8 zero write
      {OP_R, 3'd5, 16'h0000, 1'b0, 1'b0, 16'h0000},  // R8
      {OP_W, 3'd3, 16'h0001, 1'b0, 1'b0, 16'h0000},  // R8 start
      {OP_R, 3'd5, 16'h0000, 1'b0, 1'b0, 16'h0001},  // R8
      {OP_R, 3'd3, 16'h0000, 1'b0, 1'b0, 16'h0000},  // R10 start reads 0
      {OP_F, 3'd0, 16'h00A5, 1'b0, 1'b0, 16'h0000},  // R2
      {OP_R, 3'd1, 16'h0000, 1'b0, 1'b0, 16'h0040},  // R2 full
      {OP_R, 3'd0, 16'h0000, 1'b0, 1'b0, 16'h00A5},  // R2 data
      {OP_R, 3'd1, 16'h0000, 1'b0, 1'b0, 16'h0000},  // R3 freed
      {OP_F, 3'd0, 16'h0011, 1'b0, 1'b0, 16'h0000},  // R4
      {OP_F, 3'd0, 16'h0022, 1'b1, 1'b0, 16'h0000},  // R4 R5
      {OP_R, 3'd1, 16'h0000, 1'b0, 1'b0, 16'h0043},  // R4 R5
      {OP_R, 3'd0, 16'h0000, 1'b0, 1'b0, 16'h0022},  // R4 overwritten
      {OP_W, 3'd2, 16'h0002, 1'b0, 1'b0, 16'h0000},  // R6 clear parity
      {OP_R, 3'd1, 16'h0000, 1'b0, 1'b0, 16'h0001},  // R6
      {OP_F, 3'd0, 16'h0033, 1'b0, 1'b1, 16'h0000},  // R5 framing
      {OP_R, 3'd1, 16'h0000, 1'b0, 1'b0, 16'h0045},  // R5
      {OP_W, 3'd2, 16'h0045, 1'b0, 1'b0, 16'h0000},  // R6 write-back
      {OP_R, 3'd1, 16'h0000, 1'b0, 1'b0, 16'h0040},  // R6 full kept
      {OP_W, 3'd4, 16'h0001, 1'b0, 1'b0, 16'h0000},  // R8 stop
      {OP_R, 3'd5, 16'h0000, 1'b0, 1'b0, 16'h0000},  // R8
      {OP_F, 3'd0, 16'h0077, 1'b1, 1'b1, 16'h0000},  // R9 ignored
      {OP_R, 3'd0, 16'h0000, 1'b0, 1'b0, 16'h0033},  // R9
      {OP_R, 3'd1, 16'h0000, 1'b0, 1'b0, 16'h0000},  // R3 R9
      {OP_W, 3'd1, 16'h00FF, 1'b0, 1'b0, 16'h0000},  // R10 write status
      {OP_R, 3'd1, 16'h0000, 1'b0, 1'b0, 16'h0000},  // R10
      {OP_R, 3'd4, 16'h0000, 1'b0, 1'b0, 16'h0000}   // R10 stop reads 0
   };

   task automatic check(input logic [BW-1:0] act, input logic [BW-1:0] exp,
                        input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [BW-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic do_read(input logic [AW-1:0] a, input logic [BW-1:0] exp,
                          input string tag);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1ns check(bus_rdata, exp, tag);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic do_frame(input logic [DW-1:0] b, input logic p, input logic f);
      @(negedge clk);
      rx_byte = b; rx_par_err = p; rx_frm_err = f; rx_done = 1'b1;
      @(negedge clk);
      rx_done = 1'b0; rx_par_err = 1'b0; rx_frm_err = 1'b0;
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check({15'd0, rx_enable}, 16'h0000, "R1 rx_enable low");

      for (int i = 0; i < NV; i++) begin
         logic [38:0] v;
         v = VEC[i];
         case (v[38:37])
            OP_W:    do_write(v[36:34], v[33:18]);
            OP_R:    do_read(v[36:34], v[15:0], $sformatf("vector %0d", i));
            default: do_frame(v[25:18], v[17], v[16]);
         endcase
      end

      // R8 enable pin follows start
      do_write(3'd3, 16'h0001);
      check({15'd0, rx_enable}, 16'h0001, "R8 rx_enable high");

      // R3 data read and completion in the same cycle
      do_frame(8'h81, 1'b0, 1'b0);
      @(negedge clk);
      bus_addr = 3'd0; bus_rd = 1'b1;
      rx_byte = 8'h82; rx_par_err = 1'b1; rx_done = 1'b1;
      #1ns check(bus_rdata, 16'h0081, "R3 same-cycle read returns old");
      @(negedge clk);
      bus_rd = 1'b0; rx_done = 1'b0; rx_par_err = 1'b0;
      do_read(3'd1, 16'h0042, "R3 full kept, no overrun");
      do_read(3'd0, 16'h0082, "R3 new character held");

      // R7 clear and new parity error in the same cycle
      @(negedge clk);
      bus_addr = 3'd2; bus_wdata = 16'h0002; bus_wr = 1'b1;
      rx_byte = 8'h90; rx_par_err = 1'b1; rx_done = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0; rx_done = 1'b0; rx_par_err = 1'b0;
      do_read(3'd1, 16'h0042, "R7 parity survives clear");
      do_write(3'd2, 16'h0002);
      do_read(3'd1, 16'h0040, "R6 parity cleared after");

      // R1 reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check({15'd0, rx_enable}, 16'h0000, "R1 rx_enable after reset");
      do_read(3'd1, 16'h0000, "R1 status after reset");
      do_read(3'd0, 16'h0000, "R1 data after reset");
      do_read(3'd5, 16'h0000, "R1 enable status after reset");

      done_run = 1'b1;
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_run) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

endmodule